// File: doc/BRIEF.md
# End-of-Discharge Voltage Flag Monitor

This block watches a stream of digitized cell-voltage samples and raises two warning flags that mean the battery is nearly empty. The first flag trips at a programmable first threshold. The second, final flag trips at a level a fixed 25 mV below the first threshold. Once a flag is set it stays set, whatever later samples show, until the charger logic reports a valid charge event.

Heavy discharge pulls the cell voltage down for a while without the cell being empty. For that reason comparison is blanked while an overload indication is high. It stays blanked for a hold-off of 500 millisecond ticks after the overload clears. The most recent sample is kept in a register so that other logic can read it. Analog scaling, conversion, charge counting and register access over a serial link are handled elsewhere.

Top module: `edv_flag_monitor`

## Requirements
- R1: After reset both flags are 0, `mon_active` is 1, `last_mv` is 0, and the first threshold holds its default of 760 mV.
- R2: A sample accepted while monitoring is active sets `flag_first` on the next clock edge when its value is strictly less than the first threshold. A sample equal to the threshold leaves the flag unchanged.
- R3: The final threshold is the first threshold minus 25 mV, which is 735 mV by default. A sample strictly below it sets `flag_final`. Setting `flag_final` always sets `flag_first` as well, so `flag_final` = 1 implies `flag_first` = 1.
- R4: A set flag stays set through any later samples, including samples above both thresholds.
- R5: A one-cycle `charge_evt` pulse clears both flags on the next edge. If a below-threshold sample arrives in the same cycle, the clear wins.
- R6: While `overload` is 1, `mon_active` is 0 and no sample can newly set either flag.
- R7: After `overload` falls, `mon_active` stays 0 until 500 `ms_tick` pulses have been seen. It becomes 1 on the edge that registers the 500th pulse.
- R8: If `overload` rises again during the hold-off, the count reloads, and a full 500 ticks must elapse after the next fall.
- R9: A write pulse `thr_wr` loads `thr_mv` into the first threshold. Both comparisons use the new value from the next cycle on.
- R10: `last_mv` takes the value of every sample presented with `smp_valid` = 1, whether or not monitoring is active, and it holds that value otherwise.
- R11: If the programmed first threshold is below 25 mV, the final threshold saturates at 0, and `flag_final` can never be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe |
| smp_mv | input | 12 | Cell voltage sample, unsigned mV |
| thr_wr | input | 1 | Load strobe for the first threshold |
| thr_mv | input | 12 | New first threshold, unsigned mV |
| overload | input | 1 | Discharge rate above 2C |
| charge_evt | input | 1 | Valid-charge event pulse |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| flag_first | output | 1 | Latched first-level empty flag |
| flag_final | output | 1 | Latched final-level empty flag |
| mon_active | output | 1 | Comparison enabled |
| last_mv | output | 12 | Most recent sample |

## Verification
The assertions assume that `charge_evt` and `ms_tick` are single-cycle pulses and that `overload` only changes at clock edges. They also assume that samples, threshold writes and charge events are synchronous to `clk`. The bench drives every input on the falling edge and holds each pulse for exactly one cycle. It never overlaps a threshold write with a sample, so each comparison sees a settled threshold.

// File: rtl/edv_pkg.sv
package edv_pkg;
   localparam int LVL_FIRST = 0;
   localparam int LVL_FINAL = 1;
   localparam int NUM_LVL   = 2;
endpackage

// File: rtl/edv_thresh_reg.sv
module edv_thresh_reg #(
   parameter int VW      = 12,
   parameter int DEF_MV  = 760,
   parameter int OFF_MV  = 25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [VW-1:0] wdata,
   output logic [VW-1:0] thr_first,
   output logic [VW-1:0] thr_final
);
   localparam logic [VW-1:0] DEF = VW'(DEF_MV);
   localparam logic [VW-1:0] OFF = VW'(OFF_MV);

   if (DEF_MV >= (1 << VW)) begin : g_bad_def
      $error("edv_thresh_reg: default threshold exceeds sample width");
   end
   if (OFF_MV >= (1 << VW)) begin : g_bad_off
      $error("edv_thresh_reg: offset exceeds sample width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  thr_first <= DEF;
      else if (wr) thr_first <= wdata;
   end

   // final level saturates at zero for small programmed thresholds (R11)
   always_comb begin
      if (thr_first >= OFF) thr_final = thr_first - OFF;
      else                  thr_final = '0;
   end

   assert_thr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(thr_first));
endmodule

// File: rtl/edv_holdoff.sv
module edv_holdoff #(
   parameter int HOLD_MS = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic overload,
   input  logic ms_tick,
   output logic active
);
   localparam int CW = $clog2(HOLD_MS + 1);
   localparam logic [CW-1:0] RELOAD = CW'(HOLD_MS);

   if (HOLD_MS < 1) begin : g_bad_hold
      $error("edv_holdoff: hold-off must be at least one tick");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt <= '0;
      else if (overload)                 cnt <= RELOAD;
      else if (ms_tick && cnt != '0)     cnt <= cnt - 1'b1;
   end

   assign active = !overload && (cnt == '0);

   assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
      overload |=> (cnt == RELOAD));
   assert_hold_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!overload && !ms_tick) |=> $stable(cnt));
   assert_no_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!overload && cnt > 1) |=> !active);
endmodule

// File: rtl/edv_level_latch.sv
module edv_level_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic set_req,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag <= 1'b0;
      else if (clr)     flag <= 1'b0;
      else if (set_req) flag <= 1'b1;
   end

   assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !flag);
endmodule

// File: rtl/edv_flag_monitor.sv
module edv_flag_monitor
   import edv_pkg::*;
#(
   parameter int VW      = 12,
   parameter int DEF_MV  = 760,
   parameter int OFF_MV  = 25,
   parameter int HOLD_MS = 500
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic [VW-1:0] smp_mv,
   input  logic          thr_wr,
   input  logic [VW-1:0] thr_mv,
   input  logic          overload,
   input  logic          charge_evt,
   input  logic          ms_tick,
   output logic          flag_first,
   output logic          flag_final,
   output logic          mon_active,
   output logic [VW-1:0] last_mv
);
   if (VW < 2) begin : g_bad_vw
      $error("edv_flag_monitor: sample width too small");
   end

   logic [VW-1:0]      thr [NUM_LVL];
   logic [NUM_LVL-1:0] below;
   logic [NUM_LVL-1:0] set_req;
   logic [NUM_LVL-1:0] flags;

   edv_thresh_reg #(.VW(VW), .DEF_MV(DEF_MV), .OFF_MV(OFF_MV)) u_thr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (thr_wr),
      .wdata     (thr_mv),
      .thr_first (thr[LVL_FIRST]),
      .thr_final (thr[LVL_FINAL])
   );

   edv_holdoff #(.HOLD_MS(HOLD_MS)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .overload (overload),
      .ms_tick  (ms_tick),
      .active   (mon_active)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         last_mv <= '0;
      else if (smp_valid) last_mv <= smp_mv;
   end

   for (genvar i = 0; i < NUM_LVL; i++) begin : g_lvl
      assign below[i] = smp_mv < thr[i];
      // a deeper level also trips every shallower one
      if (i == NUM_LVL - 1) begin : g_last
         assign set_req[i] = smp_valid && mon_active && below[i];
      end else begin : g_mid
         assign set_req[i] = smp_valid && mon_active && (below[i] || set_req[i+1]);
      end
      edv_level_latch u_latch (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (charge_evt),
         .set_req (set_req[i]),
         .flag    (flags[i])
      );
   end

   assign flag_first = flags[LVL_FIRST];
   assign flag_final = flags[LVL_FINAL];

   assert_final_implies_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_final |-> flag_first);
   assert_no_set_overload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (overload && !flag_first) |=> !flag_first);
   assert_inactive_overload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      overload |-> !mon_active);
   assert_sample_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(last_mv));
   assert_equal_no_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !flag_first && !charge_evt && smp_mv >= thr[LVL_FIRST]) |=> !flag_first);
endmodule

// File: tb/edv_flag_monitor_tb.sv
module edv_flag_monitor_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_mv = '0;
   logic        thr_wr = 1'b0;
   logic [11:0] thr_mv = '0;
   logic        overload = 1'b0;
   logic        charge_evt = 1'b0;
   logic        ms_tick = 1'b0;
   logic        flag_first, flag_final, mon_active;
   logic [11:0] last_mv;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edv_flag_monitor u_dut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
      .thr_wr(thr_wr), .thr_mv(thr_mv), .overload(overload),
      .charge_evt(charge_evt), .ms_tick(ms_tick), .flag_first(flag_first),
      .flag_final(flag_final), .mon_active(mon_active), .last_mv(last_mv)
   );

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic sample(input int v);
      smp_valid = 1'b1; smp_mv = 12'(v);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic tick();
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
   endtask

   task automatic charge();
      charge_evt = 1'b1;
      @(negedge clk);
      charge_evt = 1'b0;
   endtask

   task automatic test_reset();
      check("R1 flag_first", flag_first, 0);
      check("R1 flag_final", flag_final, 0);
      check("R1 mon_active", mon_active, 1);
      check("R1 last_mv", last_mv, 0);
   endtask

   task automatic test_first();
      sample(760);
      check("R2 equal no set", flag_first, 0);
      check("R1 default 760", flag_first, 0);
      sample(759);
      check("R2 below sets", flag_first, 1);
      check("R2 final untouched", flag_final, 0);
      charge();
   endtask

   task automatic test_final();
      sample(735);
      check("R3 at final: first", flag_first, 1);
      check("R3 at final: final", flag_final, 0);
      charge();
      sample(734);
      check("R3 below final: final", flag_final, 1);
      check("R3 below final: first", flag_first, 1);
   endtask

   task automatic test_sticky();
      sample(4000);
      check("R4 first sticky", flag_first, 1);
      check("R4 final sticky", flag_final, 1);
      @(negedge clk);
      check("R4 idle sticky", flag_first, 1);
   endtask

   task automatic test_clear();
      charge();
      check("R5 clear first", flag_first, 0);
      check("R5 clear final", flag_final, 0);
      sample(100);
      check("R5 set again", flag_final, 1);
      charge_evt = 1'b1; smp_valid = 1'b1; smp_mv = 12'd100;
      @(negedge clk);
      charge_evt = 1'b0; smp_valid = 1'b0;
      check("R5 clear wins first", flag_first, 0);
      check("R5 clear wins final", flag_final, 0);
   endtask

   task automatic test_overload();
      overload = 1'b1;
      @(negedge clk);
      check("R6 inactive", mon_active, 0);
      sample(100);
      check("R6 no set first", flag_first, 0);
      check("R6 no set final", flag_final, 0);
      check("R10 sample kept in overload", last_mv, 100);
      overload = 1'b0;
      @(negedge clk);
      check("R7 inactive after fall", mon_active, 0);
      for (int i = 0; i < 499; i++) tick();
      check("R7 inactive at 499", mon_active, 0);
      sample(100);
      check("R7 no set in holdoff", flag_first, 0);
      tick();
      check("R7 active at 500", mon_active, 1);
      sample(700);
      check("R7 set after holdoff", flag_first, 1);
      charge();
   endtask

   task automatic test_reload();
      overload = 1'b1;
      @(negedge clk);
      overload = 1'b0;
      for (int i = 0; i < 300; i++) tick();
      overload = 1'b1;
      @(negedge clk);
      overload = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 499; i++) tick();
      check("R8 reloaded inactive", mon_active, 0);
      tick();
      check("R8 active after full", mon_active, 1);
   endtask

   task automatic test_program();
      thr_wr = 1'b1; thr_mv = 12'd1000;
      @(negedge clk);
      thr_wr = 1'b0;
      sample(1000);
      check("R9 equal new thr", flag_first, 0);
      sample(976);
      check("R9 first set", flag_first, 1);
      check("R9 final not at 976", flag_final, 0);
      sample(974);
      check("R9 final set below 975", flag_final, 1);
      charge();
      thr_wr = 1'b1; thr_mv = 12'd10;
      @(negedge clk);
      thr_wr = 1'b0;
      sample(0);
      check("R11 first set at 0", flag_first, 1);
      check("R11 final saturated", flag_final, 0);
      sample(2222);
      check("R10 last sample", last_mv, 2222);
      @(negedge clk);
      check("R10 held", last_mv, 2222);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_first();
      test_final();
      test_sticky();
      test_clear();
      test_overload();
      test_reload();
      test_program();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule